// File: doc/BRIEF.md
# HDLC Receive Packet FIFO with Status Interrupts

This block sits behind a byte-level HDLC receiver that has already found the flags, removed the stuffed bits and checked the CRC. Every received byte enters a 64-entry FIFO together with three tags: it opens a packet, it closes a packet, and the packet is good. A host drains the FIFO one byte at a time. Before each pop it looks at the head status: the empty indication and the three tags of the head byte. It stops at a closing byte and accepts the packet when the good tag is 1, or discards it when the tag is 0. It also stops when the FIFO reports empty.

Four packet-level events are latched into an event register: packet opened, packet closed, FIFO became non-empty and FIFO reached half full. A mask register selects which latched events pull the active-low interrupt line down. Reading the event register clears what was set at the moment of the read.

The input is a valid/ready stream. The line cannot be stalled, so `in_ready` is only advisory. A byte offered while `in_ready` is low is dropped and not held. The output is a valid/ready stream in which `out_ready` pops the head. Mask and event access are plain strobes.

Top module: `hrpf_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty (`out_valid`=0, `in_ready`=1), the event register and the mask are 0, and `irq_n` is 1.
- R2: Accepted bytes leave in arrival order. On each head byte `out_data`, `out_first` and `out_last` equal the values written with it.
- R3: `out_valid` is 0 exactly when the FIFO is empty. Raising `out_ready` while the FIFO is empty changes nothing.
- R4: A byte offered while 64 bytes are stored is dropped, even if a pop happens in the same cycle. Occupancy never exceeds 64, and `in_ready` is low exactly when it is 64.
- R5: The stored good tag is `in_crc_ok` AND "no byte dropped in this packet so far". Tracking restarts on an opening byte and ends on any closing byte, whether accepted or dropped. A drop therefore forces the tag on that packet's closing byte to 0.
- R6: Event bit 0 latches when an opening byte is accepted, and event bit 1 latches when a closing byte is accepted.
- R7: Event bit 2 latches when a byte is accepted into an empty FIFO.
- R8: Event bit 3 latches when occupancy rises from 31 to 32.
- R9: An `ev_rd` strobe shows the current event register on `ev_status` and clears every bit that was set. An event occurring in the same cycle stays set.
- R10: `mask_wr` loads `mask_wdata`, in which bit n enables event bit n. `irq_n` is low exactly when some latched event has its mask bit set. This takes effect the cycle after the event or the mask write.
- R11: After a read clears the causing event, `irq_n` returns high only if no other unmasked event is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | FIFO has room; a byte offered while low is dropped |
| in_data | input | 8 | Received byte |
| in_first | input | 1 | Byte opens a packet |
| in_last | input | 1 | Byte closes a packet |
| in_crc_ok | input | 1 | Packet check good (meaningful with in_last) |
| out_valid | output | 1 | Head byte present (inverse of empty) |
| out_ready | input | 1 | Pop head byte |
| out_data | output | 8 | Head byte |
| out_first | output | 1 | Head byte opens a packet |
| out_last | output | 1 | Head byte closes a packet |
| out_ok | output | 1 | Packet good tag of head byte |
| ev_rd | input | 1 | Read-and-clear strobe for the event register |
| ev_status | output | 4 | Event register: 0 open, 1 close, 2 non-empty, 3 half full |
| mask_wr | input | 1 | Load interrupt mask |
| mask_wdata | input | 4 | New mask, same bit order as events |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench runs three patterns of random packets of 1 to 10 bytes. In the balanced pattern, pops keep pace with arrivals, which tests ordering, tagging and the non-empty event on frequent empty-to-busy turns. In the write-heavy pattern, the FIFO is driven against its 64-byte limit: this separates correct dropping and forced-bad closing tags from overwrite or stall bugs, and it crosses the 32-byte mark that must raise half-full only on the way up. A final drain with no input shows that popping an empty FIFO has no effect and that read strobes clear the events for good. Throughout all patterns, random mask writes and read strobes that coincide with new events test the rule that a same-cycle event survives the clear.

// File: rtl/hrpf_pkg.sv
package hrpf_pkg;
  localparam int BYTE_W = 8;
  localparam int EV_N   = 4;
  localparam int EV_OPEN  = 0;
  localparam int EV_CLOSE = 1;
  localparam int EV_NEMPTY = 2;
  localparam int EV_HALF  = 3;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              first;
    logic              last;
    logic              ok;
  } rx_entry_t;
endpackage

// File: rtl/hrpf_tagger.sv
module hrpf_tagger
  import hrpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              in_crc_ok,
  input  logic              full,
  output rx_entry_t         entry
);
  logic drop_seen_q;
  logic drop_seen_eff;
  logic drop_now;

  // An opening byte starts a fresh packet: earlier drops no longer count.
  assign drop_seen_eff = in_first ? 1'b0 : drop_seen_q;
  assign drop_now      = in_valid & full;

  always_comb begin
    entry.data  = in_data;
    entry.first = in_first;
    entry.last  = in_last;
    entry.ok    = in_crc_ok & ~drop_seen_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_seen_q <= 1'b0;
    end else if (in_valid) begin
      if (in_last)       drop_seen_q <= 1'b0;
      else if (drop_now) drop_seen_q <= 1'b1;
      else               drop_seen_q <= drop_seen_eff;
    end
  end
endmodule

// File: rtl/hrpf_store.sv
module hrpf_store
  import hrpf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  rx_entry_t     wr_entry,
  input  logic          rd_req,
  output rx_entry_t     head,
  output logic [$clog2(DEPTH):0] fill,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = AW + 1;

  rx_entry_t         mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [FW-1:0]     cnt_q;

  assign full   = (cnt_q == FW'(DEPTH));
  assign empty  = (cnt_q == '0);
  assign wr_acc = wr_req & ~full;
  assign rd_acc = rd_req & ~empty;
  assign fill   = cnt_q;
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + AW'(1);
      if (rd_acc) rd_ptr <= rd_ptr + AW'(1);
      case ({wr_acc, rd_acc})
        2'b10:   cnt_q <= cnt_q + FW'(1);
        2'b01:   cnt_q <= cnt_q - FW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hrpf_events.sv
module hrpf_events
  import hrpf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_acc,
  input  logic                   rd_acc,
  input  logic                   wr_first,
  input  logic                   wr_last,
  input  logic [$clog2(DEPTH):0] fill,
  input  logic                   ev_rd,
  input  logic                   mask_wr,
  input  logic [EV_N-1:0]        mask_wdata,
  output logic [EV_N-1:0]        ev_q,
  output logic [EV_N-1:0]        mask_q,
  output logic                   irq_n
);
  localparam int FW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  logic [EV_N-1:0] new_ev;

  always_comb begin
    new_ev            = '0;
    new_ev[EV_OPEN]   = wr_acc & wr_first;
    new_ev[EV_CLOSE]  = wr_acc & wr_last;
    new_ev[EV_NEMPTY] = wr_acc & (fill == '0);
    new_ev[EV_HALF]   = wr_acc & ~rd_acc & (fill == FW'(HALF - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      ev_q <= ev_rd ? new_ev : (ev_q | new_ev);
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  assign irq_n = ~|(ev_q & mask_q);
endmodule

// File: rtl/hrpf_rx_fifo.sv
module hrpf_rx_fifo
  import hrpf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  input  logic              in_crc_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              out_ok,
  input  logic              ev_rd,
  output logic [EV_N-1:0]   ev_status,
  input  logic              mask_wr,
  input  logic [EV_N-1:0]   mask_wdata,
  output logic              irq_n
);
  localparam int FW = $clog2(DEPTH) + 1;

  rx_entry_t       wr_entry, head;
  logic [FW-1:0]   fill_cnt;
  logic            wr_acc, rd_acc, full, empty;
  logic [EV_N-1:0] mask_q;

  hrpf_tagger u_tag (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_crc_ok(in_crc_ok),
    .full(full), .entry(wr_entry)
  );

  hrpf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(in_valid), .wr_entry(wr_entry),
    .rd_req(out_ready), .head(head), .fill(fill_cnt), .wr_acc(wr_acc),
    .rd_acc(rd_acc), .full(full), .empty(empty)
  );

  hrpf_events #(.DEPTH(DEPTH)) u_ev (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .wr_first(in_first), .wr_last(in_last), .fill(fill_cnt),
    .ev_rd(ev_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ev_q(ev_status), .mask_q(mask_q), .irq_n(irq_n)
  );

  assign in_ready  = ~full;
  assign out_valid = ~empty;
  assign out_data  = head.data;
  assign out_first = head.first;
  assign out_last  = head.last;
  assign out_ok    = head.ok;
endmodule

// File: rtl/hrpf_checker.sv
module hrpf_checker #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_first,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic                   ev_rd,
  input logic [3:0]             ev,
  input logic [3:0]             mask,
  input logic [$clog2(DEPTH):0] fill,
  input logic                   irq_n
);
  localparam int FW = $clog2(DEPTH) + 1;

  a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FW'(DEPTH) && !out_ready) |=> fill == FW'(DEPTH));

  a_r3_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !in_valid) |=> !out_valid);

  a_r6_open_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && fill != FW'(DEPTH)) |=> ev[0]);

  a_r7_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fill == '0) |=> (ev[2] && out_valid));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && !in_valid) |=> ev == 4'b0);

  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 4'b0) |-> irq_n);
endmodule

bind hrpf_rx_fifo hrpf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
  .out_valid(out_valid), .out_ready(out_ready), .ev_rd(ev_rd),
  .ev(ev_status), .mask(mask_q), .fill(fill_cnt), .irq_n(irq_n)
);

// File: tb/hrpf_rx_fifo_tb.sv
module hrpf_rx_fifo_tb;
  localparam int DEPTH = 64;
  localparam int HALF  = DEPTH / 2;

  typedef struct packed {
    logic [7:0] data;
    logic first;
    logic last;
    logic ok;
  } m_entry_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_first = 0, in_last = 0, in_crc_ok = 0;
  logic [7:0] in_data = '0;
  logic out_ready = 0, ev_rd = 0, mask_wr = 0;
  logic [3:0] mask_wdata = '0;
  logic in_ready, out_valid, out_first, out_last, out_ok, irq_n;
  logic [7:0] out_data;
  logic [3:0] ev_status;

  always #2 clk = ~clk;

  hrpf_rx_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .in_crc_ok(in_crc_ok), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .out_ok(out_ok), .ev_rd(ev_rd), .ev_status(ev_status),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq_n(irq_n)
  );

  int n_tests = 0, n_fail = 0;
  m_entry_t q[$];
  bit m_drop = 0;
  logic [3:0] m_ev = '0, m_mask = '0;
  bit in_pkt = 0;
  int rem = 0;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_tests++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_irq_n(input logic [3:0] ev, input logic [3:0] m);
    return ~|(ev & m);
  endfunction

  task automatic compare_all();
    chk(out_valid == (q.size() > 0), "R3 out_valid", out_valid, q.size() > 0);
    chk(in_ready == (q.size() < DEPTH), "R4 in_ready", in_ready, q.size() < DEPTH);
    if (q.size() > 0 && out_valid) begin
      chk(out_data == q[0].data, "R2 data", out_data, q[0].data);
      chk(out_first == q[0].first, "R2 first tag", out_first, q[0].first);
      chk(out_last == q[0].last, "R2 last tag", out_last, q[0].last);
      chk(out_ok == q[0].ok, "R5 ok tag", out_ok, q[0].ok);
    end
    chk(ev_status == m_ev, "R9 event register", ev_status, m_ev);
    chk(irq_n == exp_irq_n(m_ev, m_mask), "R10 R11 irq_n", irq_n, exp_irq_n(m_ev, m_mask));
  endtask

  // Model one clock edge using the inputs now driven.
  task automatic model_step();
    bit wr, rd, eff;
    int sz;
    logic [3:0] nev;
    m_entry_t e;
    sz  = q.size();
    wr  = in_valid && sz < DEPTH;
    rd  = out_ready && sz > 0;
    nev = '0;
    nev[0] = wr && in_first;
    nev[1] = wr && in_last;
    nev[2] = wr && sz == 0;
    nev[3] = wr && !rd && sz == HALF - 1;
    eff = in_first ? 1'b0 : m_drop;
    if (in_valid) begin
      if (in_last) m_drop = 0;
      else if (!wr) m_drop = 1;
      else m_drop = eff;
    end
    if (rd) void'(q.pop_front());
    if (wr) begin
      e.data = in_data; e.first = in_first; e.last = in_last;
      e.ok = in_crc_ok && !eff;
      q.push_back(e);
    end
    m_ev = ev_rd ? nev : (m_ev | nev);
    if (mask_wr) m_mask = mask_wdata;
  endtask

  task automatic run_phase(input int cycles, input int p_in, input int p_out);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
      in_valid = ($urandom_range(99) < p_in);
      if (in_valid) begin
        in_first = !in_pkt;
        if (!in_pkt) begin rem = $urandom_range(1, 10); in_pkt = 1; end
        in_last = (rem == 1);
        rem--;
        if (in_last) in_pkt = 0;
        in_data = 8'($urandom);
        in_crc_ok = ($urandom_range(99) < 80);
      end else begin
        in_first = 0; in_last = 0;
      end
      out_ready  = ($urandom_range(99) < p_out);
      ev_rd      = ($urandom_range(99) < 10);
      mask_wr    = ($urandom_range(99) < 3);
      mask_wdata = 4'($urandom);
      model_step();
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(ev_status == 0, "R1 events", ev_status, 0);
    chk(irq_n == 1, "R1 irq_n", irq_n, 1);
    // R3: pop while empty has no effect
    out_ready = 1;
    model_step();
    @(negedge clk);
    compare_all();
    out_ready = 0;
    // R8 R10: enable all, fill past half with a long run, no pops
    mask_wr = 1; mask_wdata = 4'hF;
    model_step();
    @(negedge clk);
    mask_wr = 0;
    for (int i = 0; i < HALF + 2; i++) begin
      compare_all();
      in_valid = 1; in_first = (i == 0); in_last = 0; in_data = 8'(i); in_crc_ok = 1;
      model_step();
      @(negedge clk);
    end
    in_valid = 0;
    chk(ev_status[3] == 1, "R8 half full latched", ev_status[3], 1);
    chk(irq_n == 0, "R10 irq low", irq_n, 0);
    // R9: read clears; R11 irq returns high
    ev_rd = 1; model_step(); @(negedge clk); ev_rd = 0;
    chk(ev_status == 0, "R9 cleared", ev_status, 0);
    chk(irq_n == 1, "R11 irq high", irq_n, 1);
    // R4 R5: overflow then close packet with crc good -> ok forced 0
    for (int i = 0; i < DEPTH; i++) begin
      in_valid = 1; in_first = 0; in_last = 0; in_data = 8'(i + 100); in_crc_ok = 1;
      model_step(); @(negedge clk); compare_all();
    end
    chk(in_ready == 0, "R4 full", in_ready, 0);
    in_valid = 0;
    out_ready = 1; model_step(); @(negedge clk); out_ready = 0;
    in_valid = 1; in_last = 1; in_data = 8'hAA; in_crc_ok = 1;
    model_step(); @(negedge clk); in_valid = 0; in_last = 0;
    compare_all();
    in_pkt = 0;
    run_phase(300, 0, 100);
    // random phases
    run_phase(3000, 50, 50);
    run_phase(1500, 90, 8);
    run_phase(200, 0, 100);
    ev_rd = 1; model_step(); @(negedge clk); ev_rd = 0;
    chk(ev_status == 0, "R9 final clear", ev_status, 0);
    compare_all();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule